// File: doc/BRIEF.md
# Parallel Longest-Prefix-Match Route Lookup

This block resolves a 32-bit IPv4 destination address to a next-hop index and its next-hop record. It keeps one small direct-indexed table per supported prefix length. By default the lengths are 28, 24, 16, 10 and 8. All tables are addressed in the same cycle. Each one clears the host bits of the key with the complement of its prefix mask. It then uses the low bits of the remaining prefix as the table address and compares the high bits against a stored tag.

The per-length hit flags feed a priority stage that keeps only the hit from the longest prefix. The index of that surviving entry addresses a second table of next-hop records. When no length hits, the block flags a miss and falls back to a default index fixed by parameter. The lookup runs as a two-stage pipeline and accepts a new key every cycle.

Routes are added and removed through a table write port. Next-hop records are loaded through a separate record write port. Neither port shares the lookup path.

Top module: `lpm_engine`

## Requirements
- R1: A lookup presented with `lk_valid` high yields `res_valid` high exactly two clock edges later. `res_valid` is low at every other time, and back-to-back lookups are accepted every cycle.
- R2: When entries of several prefix lengths match the key, the result is the index stored at the longest matching length. The length set is 28, 24, 16, 10, 8.
- R3: Key bits below the prefix length (host bits) have no effect on whether an entry of that length matches.
- R4: An entry matches only while its valid flag is set. A table write with `tw_valid` low deletes the entry, and the next lookup then falls to a shorter prefix or a miss.
- R5: Two prefixes of one length that share table address bits but differ in upper prefix bits are told apart by the stored tag. A key with a different tag does not hit.
- R6: When no length hits, `res_miss` is 1 and `res_nhi` equals the default index (0). When a length hits, `res_miss` is 0.
- R7: `res_data` is the record stored at index `res_nhi` of the next-hop table, which is loaded through `nw_en`/`nw_idx`/`nw_data`.
- R8: A table write and a lookup on the same entry in the same cycle give the lookup the old contents. The following lookup sees the new contents.
- R9: `tw_len_sel` selects the table by the encoding 0=/28, 1=/24, 2=/16, 3=/10, 4=/8. Values 5 to 7 write no table.
- R10: Synchronous reset clears `res_valid` and invalidates every route entry, so a lookup right after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Destination IPv4 address to resolve |
| tw_en | input | 1 | Route table write strobe |
| tw_len_sel | input | 3 | Prefix-length table select (encoding in R9) |
| tw_prefix | input | 32 | Route prefix; host bits are ignored |
| tw_valid | input | 1 | 1 installs the route, 0 deletes it |
| tw_nhi | input | 6 | Next-hop index stored with the route |
| nw_en | input | 1 | Next-hop record write strobe |
| nw_idx | input | 6 | Next-hop record address |
| nw_data | input | 16 | Next-hop record contents |
| res_valid | output | 1 | Result strobe |
| res_miss | output | 1 | No prefix matched |
| res_nhi | output | 6 | Selected next-hop index |
| res_data | output | 16 | Next-hop record at `res_nhi` |

## Verification
The hardest case to reach from the ports is a table write that lands on the very entry a lookup is reading in the same cycle. The lookup must see the old entry and the next lookup the new one. The bench first installs nested /8, /16, /24 and /28 routes and deletes the /28. It then drives a lookup and a /24 delete on the same cycle and checks both results. Tag aliasing is reached by installing a /16 route and probing a key whose table address bits are equal but whose upper bits differ.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  // Host-bit mask for a prefix length: ones where the key is ignored.
  function automatic logic [31:0] lpm_host_mask(input int unsigned len);
    lpm_host_mask = (len >= 32) ? 32'd0 : (32'hFFFF_FFFF >> len);
  endfunction
endpackage

// File: rtl/lpm_len_table.sv
module lpm_len_table
  import lpm_pkg::*;
#(
  parameter int LEN  = 8,
  parameter int P    = 8,
  parameter int NH_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     lk_key,
  input  logic            wr_en,
  input  logic [31:0]     wr_key,
  input  logic            wr_valid,
  input  logic [NH_W-1:0] wr_nhi,
  output logic            hit,
  output logic [NH_W-1:0] nhi
);
  localparam int          IDX_W  = (LEN < P) ? LEN : P;
  localparam int          DEPTH  = 1 << IDX_W;
  localparam bit          HAS_TAG = (LEN > IDX_W);
  localparam int          TAG_W  = HAS_TAG ? (LEN - IDX_W) : 1;
  localparam int          LSB    = 32 - LEN;
  localparam logic [31:0] HMASK  = lpm_host_mask(LEN);

  logic [31:0]      lk_net, wr_net;
  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;

  // host bits are cleared before any address or tag bit is taken
  assign lk_net = lk_key & ~HMASK;
  assign wr_net = wr_key & ~HMASK;
  assign lk_idx = lk_net[LSB +: IDX_W];
  assign wr_idx = wr_net[LSB +: IDX_W];

  generate
    if (HAS_TAG) begin : g_tag
      assign lk_tag = lk_net[LSB+IDX_W +: TAG_W];
      assign wr_tag = wr_net[LSB+IDX_W +: TAG_W];
    end else begin : g_notag
      assign lk_tag = '0;
      assign wr_tag = '0;
    end
  endgenerate

  // tag + index payload: plain RAM, read-before-write, no reset
  logic [TAG_W+NH_W-1:0] mem [DEPTH];
  logic [TAG_W+NH_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_nhi};
    rd_q <= mem[lk_idx];
  end

  // valid flags kept in flops so reset can clear the whole table
  logic [DEPTH-1:0] vld;
  logic             rd_v_q;
  logic [TAG_W-1:0] key_tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      rd_v_q    <= 1'b0;
      key_tag_q <= '0;
    end else begin
      if (wr_en) vld[wr_idx] <= wr_valid;
      rd_v_q    <= vld[lk_idx];
      key_tag_q <= lk_tag;
    end
  end

  assign hit = rd_v_q && (rd_q[TAG_W+NH_W-1:NH_W] == key_tag_q);
  assign nhi = rd_q[NH_W-1:0];
endmodule

// File: rtl/lpm_pick.sv
module lpm_pick #(
  parameter int N    = 5,
  parameter int NH_W = 6
) (
  input  logic [N-1:0]      hit,
  input  logic [N*NH_W-1:0] nhi_flat,
  output logic [N-1:0]      grant,
  output logic              any,
  output logic [NH_W-1:0]   nhi
);
  // slot 0 holds the longest length; first hit from slot 0 wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    nhi   = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i] && !taken) begin
        grant[i] = 1'b1;
        nhi      = nhi_flat[i*NH_W +: NH_W];
        taken    = 1'b1;
      end
    end
    any = taken;
  end
endmodule

// File: rtl/lpm_nh_table.sv
module lpm_nh_table #(
  parameter int NH_W  = 6,
  parameter int NHD_W = 16
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [NH_W-1:0]  wr_idx,
  input  logic [NHD_W-1:0] wr_data,
  input  logic [NH_W-1:0]  rd_idx,
  output logic [NHD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << NH_W;
  logic [NHD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/lpm_engine.sv
module lpm_engine #(
  parameter int N_LEN         = 5,
  parameter int LENS [N_LEN]  = '{28, 24, 16, 10, 8},
  parameter int P             = 8,
  parameter int NH_W          = 6,
  parameter int NHD_W         = 16,
  parameter int DEFAULT_NHI   = 0,
  localparam int SEL_W        = (N_LEN > 1) ? $clog2(N_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [31:0]      lk_addr,
  input  logic             tw_en,
  input  logic [SEL_W-1:0] tw_len_sel,
  input  logic [31:0]      tw_prefix,
  input  logic             tw_valid,
  input  logic [NH_W-1:0]  tw_nhi,
  input  logic             nw_en,
  input  logic [NH_W-1:0]  nw_idx,
  input  logic [NHD_W-1:0] nw_data,
  output logic             res_valid,
  output logic             res_miss,
  output logic [NH_W-1:0]  res_nhi,
  output logic [NHD_W-1:0] res_data
);
  logic [N_LEN-1:0]      hit_v;
  logic [N_LEN*NH_W-1:0] nhi_flat;
  logic [N_LEN-1:0]      grant;
  logic                  pick_any;
  logic [NH_W-1:0]       pick_nhi;
  logic [NH_W-1:0]       sel_nhi;
  logic                  s1_v;

  // stage 1: every length table reads in parallel
  generate
    for (genvar g = 0; g < N_LEN; g++) begin : g_len
      lpm_len_table #(.LEN(LENS[g]), .P(P), .NH_W(NH_W)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .lk_key   (lk_addr),
        .wr_en    (tw_en && (tw_len_sel == SEL_W'(g))),
        .wr_key   (tw_prefix),
        .wr_valid (tw_valid),
        .wr_nhi   (tw_nhi),
        .hit      (hit_v[g]),
        .nhi      (nhi_flat[g*NH_W +: NH_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= lk_valid;
  end

  // stage 2: eliminate shorter hits, read the next-hop record
  lpm_pick #(.N(N_LEN), .NH_W(NH_W)) u_pick (
    .hit      (hit_v),
    .nhi_flat (nhi_flat),
    .grant    (grant),
    .any      (pick_any),
    .nhi      (pick_nhi)
  );

  assign sel_nhi = pick_any ? pick_nhi : NH_W'(DEFAULT_NHI);

  lpm_nh_table #(.NH_W(NH_W), .NHD_W(NHD_W)) u_nh (
    .clk     (clk),
    .wr_en   (nw_en),
    .wr_idx  (nw_idx),
    .wr_data (nw_data),
    .rd_idx  (sel_nhi),
    .rd_data (res_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_miss  <= 1'b0;
      res_nhi   <= '0;
    end else begin
      res_valid <= s1_v;
      res_miss  <= !pick_any;
      res_nhi   <= sel_nhi;
    end
  end
endmodule

// File: rtl/lpm_engine_chk.sv
module lpm_engine_chk #(
  parameter int N_LEN       = 5,
  parameter int NH_W        = 6,
  parameter int DEFAULT_NHI = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             res_valid,
  input logic             res_miss,
  input logic [NH_W-1:0]  res_nhi,
  input logic [N_LEN-1:0] hit_v,
  input logic [N_LEN-1:0] grant
);
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst)              since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  // R1
  lat_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2) && $past(lk_valid, 2) |-> res_valid);
  // R1
  lat_back_chk: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2) && res_valid |-> $past(lk_valid, 2));
  // R2
  one_winner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R2
  winner_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~hit_v) == '0);
  // R2
  some_winner_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_v != '0) |-> (grant != '0));
  // R6
  miss_default_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_miss |-> res_nhi == NH_W'(DEFAULT_NHI));
endmodule

bind lpm_engine lpm_engine_chk #(
  .N_LEN(N_LEN), .NH_W(NH_W), .DEFAULT_NHI(DEFAULT_NHI)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .res_valid (res_valid),
  .res_miss  (res_miss),
  .res_nhi   (res_nhi),
  .hit_v     (hit_v),
  .grant     (grant)
);

// File: tb/lpm_engine_bench.sv
`timescale 1ns/1ps
module lpm_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        tw_en = 1'b0;
  logic [2:0]  tw_len_sel = '0;
  logic [31:0] tw_prefix = '0;
  logic        tw_valid = 1'b0;
  logic [5:0]  tw_nhi = '0;
  logic        nw_en = 1'b0;
  logic [5:0]  nw_idx = '0;
  logic [15:0] nw_data = '0;
  logic        res_valid, res_miss;
  logic [5:0]  res_nhi;
  logic [15:0] res_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpm_engine u_lpm_engine (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .tw_en(tw_en), .tw_len_sel(tw_len_sel), .tw_prefix(tw_prefix),
    .tw_valid(tw_valid), .tw_nhi(tw_nhi), .nw_en(nw_en), .nw_idx(nw_idx),
    .nw_data(nw_data), .res_valid(res_valid), .res_miss(res_miss),
    .res_nhi(res_nhi), .res_data(res_data)
  );

  // {address, expected miss, expected index}
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {32'h0A010214, 1'b0, 6'd4},  // R2 /28 beats /24,/16,/8
    {32'h0A010205, 1'b0, 6'd3},  // R2 /24
    {32'h0A010909, 1'b0, 6'd2},  // R2 /16
    {32'h0AC80001, 1'b0, 6'd1},  // R2 /8
    {32'hC0AA0101, 1'b0, 6'd5},  // R3 /10 with odd host bits
    {32'hC0400000, 1'b1, 6'd0},  // R6 /10 miss
    {32'hAC100505, 1'b0, 6'd6},  // R5 owner of /16 slot
    {32'h0B100001, 1'b1, 6'd0},  // R5 same slot, other tag
    {32'h0A01021F, 1'b0, 6'd4},  // R3 all host bits set
    {32'h0A010220, 1'b0, 6'd3}   // R3 just past the /28
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_res(input logic miss, input logic [5:0] nhi, input string req);
    chk(res_valid == 1'b1, {req, " valid"}, 32'(res_valid), 32'd1);
    chk(res_miss == miss, {req, " miss"}, 32'(res_miss), 32'(miss));
    chk(res_nhi == nhi, {req, " nhi"}, 32'(res_nhi), 32'(nhi));
    chk(res_data == (16'hA000 | 16'(nhi)), {req, " R7 data"}, 32'(res_data), 32'(16'hA000 | 16'(nhi)));
  endtask

  task automatic tbl_wr(input logic [2:0] sel, input logic [31:0] pfx, input logic v, input logic [5:0] nhi);
    @(negedge clk);
    tw_en = 1'b1; tw_len_sel = sel; tw_prefix = pfx; tw_valid = v; tw_nhi = nhi;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic miss, input logic [5:0] nhi, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    chk_res(miss, nhi, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 reset valid", 32'(res_valid), 32'd0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      nw_en = 1'b1; nw_idx = 6'(i); nw_data = 16'hA000 | 16'(i);
    end
    @(negedge clk);
    nw_en = 1'b0;

    lookup(32'h0A010214, 1'b1, 6'd0, "R10 empty after reset");

    tbl_wr(3'd0, 32'h0A010210, 1'b1, 6'd4);
    tbl_wr(3'd1, 32'h0A010200, 1'b1, 6'd3);
    tbl_wr(3'd2, 32'h0A010000, 1'b1, 6'd2);
    tbl_wr(3'd4, 32'h0A000000, 1'b1, 6'd1);
    tbl_wr(3'd3, 32'hC0800000, 1'b1, 6'd5);
    tbl_wr(3'd2, 32'hAC10FFFF, 1'b1, 6'd6);  // R3 host bits on write

    // streamed table, one lookup per cycle; result two edges later (R1)
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) chk_res(VEC[i-2][6], VEC[i-2][5:0], "R1 R2 R3 R5 R6 stream");
      if (i < NV) begin
        lk_valid = 1'b1; lk_addr = VEC[i][38:7];
      end else begin
        lk_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 idle valid", 32'(res_valid), 32'd0);

    // R9 select 7 writes nothing
    tbl_wr(3'd7, 32'h0B100000, 1'b1, 6'd7);
    lookup(32'h0B100001, 1'b1, 6'd0, "R9 bad select");
    tbl_wr(3'd5, 32'h0B000000, 1'b1, 6'd7);
    lookup(32'h0B100001, 1'b1, 6'd0, "R9 select 5");

    // R4 delete the /28
    tbl_wr(3'd0, 32'h0A010210, 1'b0, 6'd0);
    lookup(32'h0A010214, 1'b0, 6'd3, "R4 deleted /28");

    // R8 lookup and /24 delete on the same edge
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h0A010214;
    tw_en = 1'b1; tw_len_sel = 3'd1; tw_prefix = 32'h0A010200; tw_valid = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0; tw_en = 1'b0;
    @(negedge clk);
    chk_res(1'b0, 6'd3, "R8 old entry");
    lookup(32'h0A010214, 1'b0, 6'd2, "R8 new entry R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule